// File: doc/BRIEF.md
# Configurable Line Bit Encoder

This block shapes a serial bit stream for the radio line. On the transmit side it takes data bits from a packet framer, one per handshake, and hands chips to a modulator through a ready/valid interface. On the receive side it takes chips from a demodulator and hands recovered data bits back to the framer. Four transforms can be switched on independently:

- a self-synchronizing scrambler built on the polynomial 1 + x^12 + x^17
- transition (differential) coding
- Manchester coding, which doubles the chip rate
- complementing of every chip

The receive path undoes the same transforms in reverse order. A synchronous clear empties the chip buffer and the receive pairing phase, and zeroes all coding state. Configuration is expected to change only while the block is idle, and a clear should follow each change.

Top module: `bitline_codec`

## Requirements
- R1: After reset, or one cycle after `clr` is high, `out_valid` and `rx_out_valid` are 0 and `in_ready` is 1. The scrambler histories, the transition levels and the receive pairing phase are all zero. For example, in transition mode a 0 sent right after a clear gives chip 0 even if the level had been 1 before the clear.
- R2: With only `cfg_invert` set, each accepted bit b yields exactly one chip equal to ~b.
- R3: With only `cfg_diff` set, each bit yields one chip. A 1 toggles the line level and a 0 keeps it. The level starts at 0, and the chip equals the level after the bit is applied.
- R4: With only `cfg_manch` set, each bit yields two chips in succession: 1 gives chips 1 then 0, and 0 gives chips 0 then 1.
- R5: With only `cfg_scram` set, each bit yields one chip c[n] = b[n] ^ c[n-12] ^ c[n-17]. History before the last clear counts as 0.
- R6: On transmit, the enabled transforms are applied in this order: scramble, transition coding, Manchester, invert.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_chip` hold. `in_ready` is 0 while two chips are waiting.
- R8: With the transmit chips looped back into `rx_chip`/`rx_valid` under the same configuration, the receive path applies invert, Manchester decode, transition decode and descramble in that order. Its `rx_out_bit` stream, one bit per `rx_out_valid` pulse in the cycle after the completing chip, reproduces the transmitted bits.
- R9: With Manchester enabled, the receiver pairs chips starting from the first chip after a clear. A pair 00 or 11 sets `rx_viol` together with that pair's `rx_out_valid`; a pair 10 or 01 leaves it 0.
- R10: The descrambler needs no alignment. When it is fed a scrambled chip stream starting mid-stream, every bit from the 18th received chip onward is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of buffers and coding state |
| cfg_invert | input | 1 | Complement every chip |
| cfg_diff | input | 1 | Enable transition coding |
| cfg_manch | input | 1 | Enable Manchester coding |
| cfg_scram | input | 1 | Enable scrambling |
| in_valid | input | 1 | Transmit data bit valid |
| in_ready | output | 1 | Transmit path can accept a bit |
| in_bit | input | 1 | Transmit data bit |
| out_valid | output | 1 | Chip available for the modulator |
| out_ready | input | 1 | Modulator takes the chip |
| out_chip | output | 1 | Chip to the modulator |
| rx_valid | input | 1 | Received chip strobe |
| rx_chip | input | 1 | Received chip |
| rx_out_valid | output | 1 | Recovered bit strobe |
| rx_out_bit | output | 1 | Recovered data bit |
| rx_viol | output | 1 | Manchester code violation on this bit |

## Verification
The bench looks for the points where coding state can slip. The first bits after a clear are checked: a design that keeps the old transition level or scrambler history puts out wrong leading chips. A second Manchester chip is checked while the modulator stalls: a buffer that overwrites or advances too early drops or repeats a chip. Chip pairs 00 and 11 are fed between good pairs: a receiver pairing on the wrong phase, or not checking pairs, misses a violation or flags a good pair. Finally, the descrambler is fed a stream cut mid-way: a descrambler whose history follows its own output instead of the line never recovers.

// File: rtl/bitline_pkg.sv
// Shared types and defaults for the line bit encoder.
// Assumes: configuration fields are quasi-static while the block is idle.
package bitline_pkg;

    // Default scrambler polynomial 1 + x^TAP + x^LEN
    localparam int SCR_LEN_DEF = 17;
    localparam int SCR_TAP_DEF = 12;

    // Transform enables
    typedef struct packed {
        logic scram;
        logic manch;
        logic diff;
        logic inv;
    } line_cfg_t;

endpackage

// File: rtl/bitline_scrambler.sv
// Self-synchronizing scrambler or descrambler for 1 + x^TAP + x^LEN.
// Output = input ^ history[TAP] ^ history[LEN]. The scrambler shifts in
// its own output; the descrambler shifts in its input (the line).
// Assumes: step pulses once per data bit; bypass (dout = din) when !en.
module bitline_scrambler #(
    parameter int LEN        = bitline_pkg::SCR_LEN_DEF,
    parameter int TAP        = bitline_pkg::SCR_TAP_DEF,
    parameter bit DESCRAMBLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic step,
    input  logic din,
    output logic dout
);
    localparam int HI = LEN - 1;
    localparam int LO = TAP - 1;

    logic [LEN-1:0] hist;
    logic           feedback;
    logic           shift_in;

    assign feedback = hist[HI] ^ hist[LO];
    assign dout     = en ? (din ^ feedback) : din;

    // Pick which stream feeds the history
    generate
        if (DESCRAMBLE) begin : g_descramble
            assign shift_in = din;
        end else begin : g_scramble
            assign shift_in = dout;
        end
    endgenerate

    // History shift register, cleared by reset or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist <= '0;
        end else if (step && en) begin
            hist <= {hist[LEN-2:0], shift_in};
        end
    end

endmodule

// File: rtl/bitline_diff.sv
// Transition coder (encode) or decoder (DECODE=1).
// Encode: level toggles on 1, output is the new level.
// Decode: output is the change between this and the previous input.
// Assumes: step pulses once per data bit; bypass when !en.
module bitline_diff #(
    parameter bit DECODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic step,
    input  logic din,
    output logic dout
);
    logic level;
    logic next_level;

    assign dout = en ? (din ^ level) : din;

    generate
        if (DECODE) begin : g_decode
            assign next_level = din;
        end else begin : g_encode
            assign next_level = dout;
        end
    endgenerate

    // Stored line level
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            level <= 1'b0;
        end else if (step && en) begin
            level <= next_level;
        end
    end

endmodule

// File: rtl/bitline_tx.sv
// Transmit chain: scramble -> transition code -> Manchester -> invert.
// Holds up to two chips; accepts a new bit when empty or when the last
// waiting chip leaves in the same cycle.
// Assumes: configuration stable while bits are in flight.
module bitline_tx
    import bitline_pkg::*;
#(
    parameter int SCR_LEN = SCR_LEN_DEF,
    parameter int SCR_TAP = SCR_TAP_DEF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  line_cfg_t cfg,
    input  logic      in_valid,
    output logic      in_ready,
    input  logic      in_bit,
    output logic      out_valid,
    input  logic      out_ready,
    output logic      out_chip
);
    logic [1:0] cnt;
    logic       chip_now;
    logic       chip_next;
    logic       accept;
    logic       pop;
    logic       scr_bit;
    logic       dif_bit;

    assign out_valid = (cnt != 2'd0);
    assign out_chip  = chip_now ^ cfg.inv;
    assign pop       = out_valid && out_ready;
    assign in_ready  = (cnt == 2'd0) || ((cnt == 2'd1) && out_ready);
    assign accept    = in_valid && in_ready;

    bitline_scrambler #(
        .LEN(SCR_LEN), .TAP(SCR_TAP), .DESCRAMBLE(1'b0)
    ) u_scr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(cfg.scram),
        .step(accept), .din(in_bit), .dout(scr_bit)
    );

    bitline_diff #(.DECODE(1'b0)) u_dif (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(cfg.diff),
        .step(accept), .din(scr_bit), .dout(dif_bit)
    );

    // Chip buffer: load one or two chips per bit, shift as chips leave
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt       <= 2'd0;
            chip_now  <= 1'b0;
            chip_next <= 1'b0;
        end else if (accept) begin
            chip_now  <= dif_bit;
            chip_next <= ~dif_bit;
            cnt       <= cfg.manch ? 2'd2 : 2'd1;
        end else if (pop) begin
            chip_now <= chip_next;
            cnt      <= cnt - 2'd1;
        end
    end

    // R7: a stalled chip must not change or vanish
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_chip)));

    // R4: an accepted bit always presents a chip on the next cycle
    a_r4_chip_after_accept: assert property (@(posedge clk) disable iff (!rst_n || clr)
        accept |=> out_valid);

endmodule

// File: rtl/bitline_rx.sv
// Receive chain: invert -> Manchester decode -> transition decode ->
// descramble. Registers the recovered bit and a code-violation flag.
// Assumes: chips arrive one per rx_valid; first chip after clear starts a pair.
module bitline_rx
    import bitline_pkg::*;
#(
    parameter int SCR_LEN = SCR_LEN_DEF,
    parameter int SCR_TAP = SCR_TAP_DEF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  line_cfg_t cfg,
    input  logic      rx_valid,
    input  logic      rx_chip,
    output logic      rx_out_valid,
    output logic      rx_out_bit,
    output logic      rx_viol
);
    logic chip_c;
    logic phase;
    logic first;
    logic done;
    logic raw_bit;
    logic bad_pair;
    logic undif_bit;
    logic plain_bit;

    assign chip_c   = rx_chip ^ cfg.inv;
    assign done     = rx_valid && (!cfg.manch || phase);
    assign raw_bit  = cfg.manch ? first : chip_c;
    assign bad_pair = cfg.manch && (first == chip_c);

    // Manchester pairing phase and first chip of the pair
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= 1'b0;
            first <= 1'b0;
        end else if (rx_valid && cfg.manch) begin
            phase <= ~phase;
            if (!phase) begin
                first <= chip_c;
            end
        end
    end

    bitline_diff #(.DECODE(1'b1)) u_dif (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(cfg.diff),
        .step(done), .din(raw_bit), .dout(undif_bit)
    );

    bitline_scrambler #(
        .LEN(SCR_LEN), .TAP(SCR_TAP), .DESCRAMBLE(1'b1)
    ) u_dscr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(cfg.scram),
        .step(done), .din(undif_bit), .dout(plain_bit)
    );

    // Output register for the recovered bit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rx_out_valid <= 1'b0;
            rx_out_bit   <= 1'b0;
            rx_viol      <= 1'b0;
        end else begin
            rx_out_valid <= done;
            rx_out_bit   <= done ? plain_bit : 1'b0;
            rx_viol      <= done && bad_pair;
        end
    end

    // R9: a violation is only reported with a recovered bit
    a_r9_viol_with_valid: assert property (@(posedge clk) disable iff (!rst_n || clr)
        rx_viol |-> rx_out_valid);

    // R4: Manchester decode yields at most one bit every two cycles
    a_r4_half_rate: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (rx_out_valid && cfg.manch) |=> !rx_out_valid);

endmodule

// File: rtl/bitline_codec.sv
// Top of the line bit encoder: transmit chain and receive chain sharing
// one configuration and one synchronous clear.
// Assumes: configuration changes only while idle, followed by a clear.
module bitline_codec
    import bitline_pkg::*;
#(
    parameter int SCR_LEN = SCR_LEN_DEF,
    parameter int SCR_TAP = SCR_TAP_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cfg_invert,
    input  logic cfg_diff,
    input  logic cfg_manch,
    input  logic cfg_scram,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    output logic out_valid,
    input  logic out_ready,
    output logic out_chip,
    input  logic rx_valid,
    input  logic rx_chip,
    output logic rx_out_valid,
    output logic rx_out_bit,
    output logic rx_viol
);
    line_cfg_t cfg;

    assign cfg = '{scram: cfg_scram, manch: cfg_manch, diff: cfg_diff, inv: cfg_invert};

    bitline_tx #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg(cfg),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
        .out_valid(out_valid), .out_ready(out_ready), .out_chip(out_chip)
    );

    bitline_rx #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg(cfg),
        .rx_valid(rx_valid), .rx_chip(rx_chip),
        .rx_out_valid(rx_out_valid), .rx_out_bit(rx_out_bit), .rx_viol(rx_viol)
    );

    // Line-side tracker of Manchester chip pairs for the pair check
    logic chk_phase;
    logic chk_first;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            chk_phase <= 1'b0;
            chk_first <= 1'b0;
        end else if (out_valid && out_ready && cfg_manch) begin
            chk_phase <= ~chk_phase;
            chk_first <= out_chip;
        end
    end

    // R4: the two chips of a transmitted Manchester pair differ
    a_r4_pair_differs: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (out_valid && out_ready && cfg_manch && chk_phase) |-> (out_chip != chk_first));

    // R1: a clear empties both paths on the next cycle
    a_r1_clear_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!out_valid && !rx_out_valid));

endmodule

// File: tb/bitline_codec_tb.sv
`timescale 1ns/1ps
module bitline_codec_tb;

    logic clk = 1'b0;
    logic rst_n, clr;
    logic cfg_invert, cfg_diff, cfg_manch, cfg_scram;
    logic in_valid, in_ready, in_bit;
    logic out_valid, out_ready, out_chip;
    logic rx_valid, rx_chip, rx_out_valid, rx_out_bit, rx_viol;
    logic loop_en, rx_man_valid, rx_man_chip, log_clr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    assign rx_valid = loop_en ? (out_valid && out_ready) : rx_man_valid;
    assign rx_chip  = loop_en ? out_chip : rx_man_chip;

    bitline_codec u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .cfg_invert(cfg_invert), .cfg_diff(cfg_diff),
        .cfg_manch(cfg_manch), .cfg_scram(cfg_scram),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
        .out_valid(out_valid), .out_ready(out_ready), .out_chip(out_chip),
        .rx_valid(rx_valid), .rx_chip(rx_chip),
        .rx_out_valid(rx_out_valid), .rx_out_bit(rx_out_bit), .rx_viol(rx_viol)
    );

    // Vector: config {scram,manch,diff,inv}, bits (bit 0 sent first), chips
    typedef struct packed {
        logic [3:0]  cfg;
        logic [4:0]  nbits;
        logic [15:0] data;
        logic [5:0]  nchips;
        logic [31:0] chips;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'h0, 5'd8,  16'h004D, 6'd8,  32'h0000004D},
        '{4'h1, 5'd8,  16'h004D, 6'd8,  32'h000000B2},
        '{4'h2, 5'd8,  16'h004D, 6'd8,  32'h0000003B},
        '{4'h4, 5'd4,  16'h0009, 6'd8,  32'h00000069},
        '{4'h8, 5'd16, 16'h3001, 6'd16, 32'h00002001},
        '{4'hF, 5'd4,  16'h000B, 6'd8,  32'h00000096},
        '{4'h6, 5'd4,  16'h0006, 6'd8,  32'h000000A6},
        '{4'h3, 5'd4,  16'h0004, 6'd4,  32'h00000003}
    };

    // Monitor: logs transferred chips and recovered bits at the falling edge
    logic tx_log   [64];
    logic rx_log   [64];
    logic viol_log [64];
    int   tx_n = 0;
    int   rx_n = 0;

    always @(negedge clk) begin
        if (log_clr) begin
            tx_n = 0;
            rx_n = 0;
        end else begin
            if (out_valid && out_ready && tx_n < 64) begin
                tx_log[tx_n] = out_chip;
                tx_n++;
            end
            if (rx_out_valid && rx_n < 64) begin
                rx_log[rx_n]   = rx_out_bit;
                viol_log[rx_n] = rx_viol;
                rx_n++;
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] c);
        cfg_invert = c[0];
        cfg_diff   = c[1];
        cfg_manch  = c[2];
        cfg_scram  = c[3];
    endtask

    task automatic do_clear();
        clr = 1'b1;
        tick();
        clr = 1'b0;
        log_clr = 1'b1;
        tick();
        log_clr = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        in_valid = 1'b1;
        in_bit   = b;
        while (!in_ready) tick();
        tick();
        in_valid = 1'b0;
    endtask

    task automatic rx_send(input logic c);
        rx_man_valid = 1'b1;
        rx_man_chip  = c;
        tick();
        rx_man_valid = 1'b0;
    endtask

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'h1:    return "R2";
            4'h2:    return "R3";
            4'h4:    return "R4";
            4'h8:    return "R5";
            4'h0:    return "R8";
            default: return "R6";
        endcase
    endfunction

    logic [31:0] got;
    logic [31:0] mask;
    logic        saved [30];
    logic [29:0] pat;
    bit          ok;

    initial begin
        rst_n = 1'b0; clr = 1'b0; log_clr = 1'b0;
        set_cfg(4'h0);
        in_valid = 1'b0; in_bit = 1'b0; out_ready = 1'b1;
        loop_en = 1'b1; rx_man_valid = 1'b0; rx_man_chip = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check(!out_valid && !rx_out_valid && in_ready, "R1 reset state",
              {29'd0, out_valid, rx_out_valid, in_ready}, 32'h1);

        // Vector table: transmit chips and looped-back receive bits
        for (int v = 0; v < 8; v++) begin
            set_cfg(VECS[v].cfg);
            loop_en = 1'b1;
            out_ready = 1'b1;
            do_clear();
            for (int i = 0; i < int'(VECS[v].nbits); i++) send_bit(VECS[v].data[i]);
            repeat (6) tick();
            got = '0;
            for (int i = 0; i < tx_n && i < 32; i++) got[i] = tx_log[i];
            mask = (VECS[v].nchips == 6'd32) ? 32'hFFFF_FFFF
                                             : ((32'h1 << VECS[v].nchips) - 32'h1);
            check((tx_n == int'(VECS[v].nchips)) && ((got & mask) == VECS[v].chips),
                  tag_of(VECS[v].cfg), got, VECS[v].chips);
            got = '0;
            for (int i = 0; i < rx_n && i < 32; i++) got[i] = rx_log[i];
            check((rx_n == int'(VECS[v].nbits)) && (got[15:0] == VECS[v].data),
                  "R8 loopback", got, {16'd0, VECS[v].data});
        end

        // R7: stalled Manchester pair stays put
        set_cfg(4'h4);
        do_clear();
        out_ready = 1'b0;
        send_bit(1'b1);
        tick();
        check(out_valid && out_chip && !in_ready, "R7 stall first chip",
              {29'd0, out_valid, out_chip, in_ready}, 32'h6);
        tick();
        check(out_valid && out_chip, "R7 stall hold",
              {30'd0, out_valid, out_chip}, 32'h3);
        out_ready = 1'b1;
        tick();
        check(out_valid && !out_chip, "R4 second chip after stall",
              {30'd0, out_valid, out_chip}, 32'h2);
        tick();
        check(!out_valid && in_ready, "R7 drained",
              {30'd0, out_valid, in_ready}, 32'h1);

        // R9: Manchester code violations on the receive side
        loop_en = 1'b0;
        set_cfg(4'h4);
        do_clear();
        rx_send(1'b1); rx_send(1'b1);
        rx_send(1'b0); rx_send(1'b1);
        rx_send(1'b0); rx_send(1'b0);
        repeat (3) tick();
        ok = (rx_n == 3) && viol_log[0] && !viol_log[1] && viol_log[2] && !rx_log[1];
        check(ok, "R9 violation flags", {rx_n[27:0], viol_log[0], viol_log[1],
              viol_log[2], rx_log[1]}, {28'd3, 4'b1010});

        // R10: descrambler locks on a stream entered mid-way
        set_cfg(4'h8);
        loop_en = 1'b0;
        out_ready = 1'b1;
        do_clear();
        pat = 30'h2B5C_3A9;
        for (int i = 0; i < 30; i++) send_bit(pat[i]);
        repeat (4) tick();
        for (int i = 0; i < 30; i++) saved[i] = tx_log[i];
        do_clear();
        for (int k = 5; k < 30; k++) rx_send(saved[k]);
        repeat (3) tick();
        ok = (rx_n == 25);
        got = '0;
        for (int j = 17; j < 25; j++) begin
            got[j-17] = rx_log[j];
            if (rx_log[j] != pat[j+5]) ok = 1'b0;
        end
        check(ok, "R10 self-sync", got, {24'd0, pat[29:22]});

        // R1: clear zeroes the transition level mid-stream
        set_cfg(4'h2);
        loop_en = 1'b1;
        do_clear();
        send_bit(1'b1);
        repeat (3) tick();
        do_clear();
        send_bit(1'b0);
        repeat (3) tick();
        check((tx_n == 1) && !tx_log[0], "R1 clear resets level",
              {31'd0, tx_log[0]}, 32'h0);

        summary();
        $finish;
    end

endmodule